// File: doc/BRIEF.md
# Per-lane buffer address generator

This block turns one lane of a vector buffer access into a memory address and an out-of-bounds verdict. Each request carries a buffer resource descriptor (base address, stride, record count, swizzle enable and two small size codes), a scalar offset, an instruction offset, and for the lane a vector offset, an index, a lane number and a load/store flag. The block forms the lane's byte offset inside the buffer, either linearly or with the swizzled (interleaved) layout. It range-checks that final offset and adds the base.

One lane is accepted per cycle on a valid/ready handshake, and its result appears in order exactly two cycles later, tagged with its lane number. A lane found out of range gets a zero address and raises a load-zero qualifier for loads or a store-suppress qualifier for stores. The issuing logic collects these verdicts by lane number into its per-lane mask. The memory access itself, data formatting and any caching stay outside.

Top module: `buf_addr_gen`

## Requirements
- R1: The raw lane offset is `vec_off + inst_off` at DATA_W+1 bits, keeping the carry out.
- R2: With `swz_en` = 0 the buffer offset is raw offset + `stride` × `index`, formed at full width with no truncation.
- R3: With `swz_en` = 1, let the index stride be 8 << `idx_code` and the element size be 2 << `elem_code` (both codes 2 bits). Split the index into quotient q_i and remainder r_i by the index stride, and the raw offset into q_o and r_o by the element size. The buffer offset is (q_i × `stride` + q_o × elem) × idx_stride + r_i × elem + r_o.
- R4: When `swz_en` = 0 or `stride` = 0, a lane is out of range exactly when its computed buffer offset (swizzled or linear) is ≥ `num_rec` − `scalar_off`.
- R5: When `scalar_off` ≥ `num_rec`, the limit of R4 is zero and every lane checked under R4 is out of range.
- R6: When `swz_en` = 1 and `stride` ≠ 0, a lane is out of range exactly when `index` ≥ `num_rec` or raw offset ≥ `stride`. `scalar_off` has no effect on this check.
- R7: `out_addr` is (`base` + buffer offset) modulo 2^ADDR_W for an in-range lane, and 0 for an out-of-range lane.
- R8: `out_load_zero` = `out_oob` AND NOT store, and `out_store_kill` = `out_oob` AND store, where `is_store` = 1 marks a store.
- R9: `in_ready` is 1 from the first clock after reset. An accepted lane appears on `out_valid` with its `out_lane` exactly two cycles later, in order, at one lane per cycle.
- R10: During reset `in_ready` and `out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Lane request valid |
| in_ready | output | 1 | Block accepts a lane |
| in_lane | input | LANE_W | Lane number of the request |
| is_store | input | 1 | 1 = store, 0 = load |
| base | input | ADDR_W | Descriptor base address |
| stride | input | DATA_W | Descriptor stride in bytes |
| num_rec | input | DATA_W | Descriptor record count |
| swz_en | input | 1 | Swizzled addressing enable |
| idx_code | input | CODE_W | Index-stride code |
| elem_code | input | CODE_W | Element-size code |
| scalar_off | input | DATA_W | Scalar offset |
| inst_off | input | DATA_W | Instruction offset |
| vec_off | input | DATA_W | Lane vector offset |
| index | input | DATA_W | Lane index |
| out_valid | output | 1 | Result valid |
| out_lane | output | LANE_W | Lane number of the result |
| out_addr | output | ADDR_W | Lane address |
| out_oob | output | 1 | Lane out of range |
| out_load_zero | output | 1 | Load must return zero |
| out_store_kill | output | 1 | Store write suppressed |

## Verification
The bench builds the block at its defaults: DATA_W 32, ADDR_W 48, CODE_W 2 and LANE_W 6. At these values an all-ones offset sum and a 32×32 product both overflow 32 bits, so a truncated datapath turns an out-of-range lane into an in-range one and shows in the verdict. Swizzled cases cover several code values, including a zero stride where only the true swizzled offset decides the limit. Lane tags reach 63 and go back-to-back, so the two-cycle in-order latency is seen under a full stream.

// File: rtl/bag_pkg.sv
package bag_pkg;
  localparam int unsigned IDX_STRIDE_LOG2 = 3;
  localparam int unsigned ELEM_SIZE_LOG2  = 1;

  typedef enum logic {
    CHK_LINEAR  = 1'b0,
    CHK_SWIZZLE = 1'b1
  } bag_chk_e;
endpackage

// File: rtl/bag_offset_calc.sv
module bag_offset_calc #(
  parameter int DATA_W = 32,
  parameter int CODE_W = 2,
  parameter int OFF_W  = 2 * DATA_W + 8
) (
  input  logic [DATA_W-1:0] vec_off,
  input  logic [DATA_W-1:0] inst_off,
  input  logic [DATA_W-1:0] index,
  input  logic [DATA_W-1:0] stride,
  input  logic              swz_en,
  input  logic [CODE_W-1:0] idx_code,
  input  logic [CODE_W-1:0] elem_code,
  output logic [DATA_W:0]   raw_off,
  output logic [OFF_W-1:0]  buf_off
);
  import bag_pkg::*;

  logic [7:0]       idx_sh;
  logic [7:0]       elem_sh;
  logic [OFF_W-1:0] lin_off;
  logic [OFF_W-1:0] swz_off;

  function automatic logic [OFF_W-1:0] f_linear(
    input logic [DATA_W:0]   r,
    input logic [DATA_W-1:0] s,
    input logic [DATA_W-1:0] i
  );
    return OFF_W'(r) + OFF_W'(s) * OFF_W'(i);
  endfunction

  function automatic logic [OFF_W-1:0] f_swizzle(
    input logic [DATA_W:0]   r,
    input logic [DATA_W-1:0] s,
    input logic [DATA_W-1:0] i,
    input logic [7:0]        ish,
    input logic [7:0]        esh
  );
    logic [OFF_W-1:0] one, iw, rw, q_i, r_i, q_o, r_o;
    one = OFF_W'(1);
    iw  = OFF_W'(i);
    rw  = OFF_W'(r);
    q_i = iw >> ish;
    r_i = iw & ((one << ish) - one);
    q_o = rw >> esh;
    r_o = rw & ((one << esh) - one);
    return (((q_i * OFF_W'(s)) + (q_o << esh)) << ish) + (r_i << esh) + r_o;
  endfunction

  always_comb begin
    raw_off = {1'b0, vec_off} + {1'b0, inst_off};
    idx_sh  = 8'(IDX_STRIDE_LOG2) + 8'(idx_code);
    elem_sh = 8'(ELEM_SIZE_LOG2) + 8'(elem_code);
    lin_off = f_linear(raw_off, stride, index);
    swz_off = f_swizzle(raw_off, stride, index, idx_sh, elem_sh);
    buf_off = swz_en ? swz_off : lin_off;
  end
endmodule

// File: rtl/bag_range_check.sv
module bag_range_check #(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 2 * DATA_W + 8
) (
  input  logic [DATA_W:0]   raw_off,
  input  logic [OFF_W-1:0]  buf_off,
  input  logic [DATA_W-1:0] index,
  input  logic [DATA_W-1:0] stride,
  input  logic [DATA_W-1:0] num_rec,
  input  logic [DATA_W-1:0] scalar_off,
  input  logic              swz_en,
  output bag_pkg::bag_chk_e chk_mode,
  output logic [DATA_W-1:0] lin_limit,
  output logic              oob
);
  import bag_pkg::*;

  function automatic logic [DATA_W-1:0] f_limit(
    input logic [DATA_W-1:0] n,
    input logic [DATA_W-1:0] s
  );
    return (s >= n) ? '0 : n - s;
  endfunction

  function automatic logic f_swz_fail(
    input logic [DATA_W-1:0] i,
    input logic [DATA_W-1:0] n,
    input logic [DATA_W:0]   r,
    input logic [DATA_W-1:0] s
  );
    return (i >= n) || (r >= {1'b0, s});
  endfunction

  always_comb begin
    chk_mode  = (swz_en && (stride != '0)) ? CHK_SWIZZLE : CHK_LINEAR;
    lin_limit = f_limit(num_rec, scalar_off);
    if (chk_mode == CHK_SWIZZLE)
      oob = f_swz_fail(index, num_rec, raw_off, stride);
    else
      oob = buf_off >= OFF_W'(lin_limit);
  end
endmodule

// File: rtl/buf_addr_gen.sv
module buf_addr_gen #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 48,
  parameter int CODE_W = 2,
  parameter int LANE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LANE_W-1:0] in_lane,
  input  logic              is_store,
  input  logic [ADDR_W-1:0] base,
  input  logic [DATA_W-1:0] stride,
  input  logic [DATA_W-1:0] num_rec,
  input  logic              swz_en,
  input  logic [CODE_W-1:0] idx_code,
  input  logic [CODE_W-1:0] elem_code,
  input  logic [DATA_W-1:0] scalar_off,
  input  logic [DATA_W-1:0] inst_off,
  input  logic [DATA_W-1:0] vec_off,
  input  logic [DATA_W-1:0] index,
  output logic              out_valid,
  output logic [LANE_W-1:0] out_lane,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_oob,
  output logic              out_load_zero,
  output logic              out_store_kill
);
  import bag_pkg::*;

  localparam int OFF_W = 2 * DATA_W + 8;

  logic              accept;
  logic [DATA_W:0]   raw_off;
  logic [OFF_W-1:0]  buf_off;
  bag_chk_e          chk_mode;
  logic [DATA_W-1:0] lin_limit;
  logic              lane_oob;

  logic              s1_valid;
  logic [LANE_W-1:0] s1_lane;
  logic              s1_store;
  logic              s1_oob;
  logic [ADDR_W-1:0] s1_base;
  logic [ADDR_W-1:0] s1_off;
  logic [ADDR_W-1:0] s1_sum;

  assign accept = in_valid && in_ready;

  bag_offset_calc #(.DATA_W(DATA_W), .CODE_W(CODE_W), .OFF_W(OFF_W)) i_calc (
    .vec_off  (vec_off),
    .inst_off (inst_off),
    .index    (index),
    .stride   (stride),
    .swz_en   (swz_en),
    .idx_code (idx_code),
    .elem_code(elem_code),
    .raw_off  (raw_off),
    .buf_off  (buf_off)
  );

  bag_range_check #(.DATA_W(DATA_W), .OFF_W(OFF_W)) i_range (
    .raw_off   (raw_off),
    .buf_off   (buf_off),
    .index     (index),
    .stride    (stride),
    .num_rec   (num_rec),
    .scalar_off(scalar_off),
    .swz_en    (swz_en),
    .chk_mode  (chk_mode),
    .lin_limit (lin_limit),
    .oob       (lane_oob)
  );

  // Stage 1: offset and verdict registered.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_ready <= 1'b0;
      s1_valid <= 1'b0;
      s1_lane  <= '0;
      s1_store <= 1'b0;
      s1_oob   <= 1'b0;
      s1_base  <= '0;
      s1_off   <= '0;
    end else begin
      in_ready <= 1'b1;
      s1_valid <= accept;
      if (accept) begin
        s1_lane  <= in_lane;
        s1_store <= is_store;
        s1_oob   <= lane_oob;
        s1_base  <= base;
        s1_off   <= buf_off[ADDR_W-1:0];
      end
    end
  end

  assign s1_sum = s1_base + s1_off;

  // Stage 2: address and qualifiers.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_lane       <= '0;
      out_addr       <= '0;
      out_oob        <= 1'b0;
      out_load_zero  <= 1'b0;
      out_store_kill <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_lane       <= s1_lane;
        out_addr       <= s1_oob ? '0 : s1_sum;
        out_oob        <= s1_oob;
        out_load_zero  <= s1_oob && !s1_store;
        out_store_kill <= s1_oob && s1_store;
      end
    end
  end

  assert_lin_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && chk_mode == CHK_LINEAR && buf_off >= OFF_W'(lin_limit)) |=> s1_oob);
  assert_sat_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && chk_mode == CHK_LINEAR && scalar_off >= num_rec) |=> s1_oob);
  assert_swz_stride_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && chk_mode == CHK_SWIZZLE && raw_off >= {1'b0, stride}) |=> s1_oob);
  assert_oob_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_oob) |-> (out_addr == '0));
  assert_qual_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_load_zero && out_store_kill) && ((out_load_zero || out_store_kill) == out_oob));
  assert_stage1_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> s1_valid);
  assert_stage2_R9: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> (out_valid && out_lane == $past(s1_lane)));
  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !out_valid);
endmodule

// File: tb/test_buf_addr_gen.sv
`timescale 1ns/1ps
module test_buf_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [5:0]  in_lane = '0;
  logic        is_store = 1'b0;
  logic [47:0] d_base = '0;
  logic [31:0] d_stride = '0, d_num = '0, d_soff = '0, l_inst = '0, l_voff = '0, l_idx = '0;
  logic        d_swz = 1'b0;
  logic [1:0]  d_icode = '0, d_ecode = '0;
  logic        out_valid, out_oob, out_load_zero, out_store_kill;
  logic [5:0]  out_lane;
  logic [47:0] out_addr;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  buf_addr_gen i_buf_addr_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_lane(in_lane), .is_store(is_store), .base(d_base), .stride(d_stride),
    .num_rec(d_num), .swz_en(d_swz), .idx_code(d_icode), .elem_code(d_ecode),
    .scalar_off(d_soff), .inst_off(l_inst), .vec_off(l_voff), .index(l_idx),
    .out_valid(out_valid), .out_lane(out_lane), .out_addr(out_addr),
    .out_oob(out_oob), .out_load_zero(out_load_zero), .out_store_kill(out_store_kill)
  );

  task automatic chk(input string tag, input logic [79:0] got, input logic [79:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, got, exp);
    end
  endtask

  // Reference model written with division and remainder.
  function automatic logic [79:0] m_off();
    logic [79:0] raw, istr, esz, ix;
    raw  = 80'(l_voff) + 80'(l_inst);
    istr = 80'(8 * (1 << d_icode));
    esz  = 80'(2 * (1 << d_ecode));
    ix   = 80'(l_idx);
    if (!d_swz) return raw + 80'(d_stride) * ix;
    return ((ix / istr) * 80'(d_stride) + (raw / esz) * esz) * istr + (ix % istr) * esz + raw % esz;
  endfunction

  function automatic bit m_oob();
    logic [79:0] raw, lim;
    raw = 80'(l_voff) + 80'(l_inst);
    if (d_swz && d_stride != 0) return (l_idx >= d_num) || (raw >= 80'(d_stride));
    lim = (d_soff >= d_num) ? 80'(0) : 80'(d_num - d_soff);
    return m_off() >= lim;
  endfunction

  function automatic logic [47:0] m_addr();
    logic [79:0] o;
    o = m_off();
    return m_oob() ? 48'h0 : d_base + o[47:0];
  endfunction

  task automatic run_one(input string tag, input logic [5:0] lane, input bit st);
    logic [47:0] ea;
    bit eo;
    @(negedge clk);
    in_lane = lane; is_store = st; in_valid = 1'b1;
    ea = m_addr(); eo = m_oob();
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R9 valid"}, 80'(out_valid), 80'(1));
    chk({tag, " R9 lane"}, 80'(out_lane), 80'(lane));
    chk({tag, " R4/R6 oob"}, 80'(out_oob), 80'(eo));
    chk({tag, " R7 addr"}, 80'(out_addr), 80'(ea));
    chk({tag, " R8 load_zero"}, 80'(out_load_zero), 80'(eo && !st));
    chk({tag, " R8 store_kill"}, 80'(out_store_kill), 80'(eo && st));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10 in_ready in reset", 80'(in_ready), 80'(0));
    chk("R10 out_valid in reset", 80'(out_valid), 80'(0));
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R9 in_ready after reset", 80'(in_ready), 80'(1));
    chk("R9 idle out_valid", 80'(out_valid), 80'(0));
  endtask

  task automatic t_linear();
    d_base = 48'h1000_0000_0000; d_stride = 16; d_num = 1000; d_soff = 0; d_swz = 0;
    l_voff = 32'h20; l_inst = 4; l_idx = 5;
    run_one("R1 R2 linear", 6'd3, 1'b0);
    chk("R2 linear addr value", 80'(out_addr), 80'(48'h1000_0000_0074));
  endtask

  task automatic t_lin_edge();
    d_base = 48'h40; d_stride = 0; d_num = 200; d_soff = 50; d_swz = 0;
    l_inst = 0; l_idx = 7;
    l_voff = 149; run_one("R4 last in-range", 6'd1, 1'b0);
    chk("R4 offset limit-1 in range", 80'(out_oob), 80'(0));
    l_voff = 150; run_one("R4 at limit load", 6'd2, 1'b0);
    chk("R4 offset at limit out", 80'(out_oob), 80'(1));
    run_one("R8 at limit store", 6'd2, 1'b1);
    chk("R8 store kill", 80'(out_store_kill), 80'(1));
  endtask

  task automatic t_sat();
    d_num = 200; d_soff = 300; d_swz = 0; d_stride = 4; l_voff = 0; l_inst = 0; l_idx = 0;
    run_one("R5 soff above count", 6'd4, 1'b0);
    chk("R5 saturated limit", 80'(out_oob), 80'(1));
    d_soff = 200;
    run_one("R5 soff equals count", 6'd5, 1'b0);
    chk("R5 zero limit", 80'(out_oob), 80'(1));
  endtask

  task automatic t_swz();
    d_base = 48'h8000; d_swz = 1; d_icode = 1; d_ecode = 1; d_stride = 64;
    d_num = 100; d_soff = 0; l_idx = 37; l_voff = 50; l_inst = 3;
    run_one("R3 swizzle", 6'd6, 1'b0);
    chk("R3 swizzle addr value", 80'(out_addr), 80'(48'h8000 + 48'd2901));
    d_icode = 3; d_ecode = 2; l_idx = 90; l_voff = 21;
    run_one("R3 swizzle codes 3/2", 6'd7, 1'b1);
    d_icode = 0; d_ecode = 3; l_idx = 13; l_voff = 60;
    run_one("R3 swizzle codes 0/3", 6'd8, 1'b0);
  endtask

  task automatic t_swz_oob();
    d_swz = 1; d_icode = 0; d_ecode = 0; d_stride = 64; d_num = 100; d_soff = 1000; l_inst = 0;
    l_idx = 99; l_voff = 63;
    run_one("R6 in range ignores soff", 6'd9, 1'b0);
    chk("R6 soff has no effect", 80'(out_oob), 80'(0));
    l_idx = 100;
    run_one("R6 index at count", 6'd10, 1'b0);
    chk("R6 index oob", 80'(out_oob), 80'(1));
    l_idx = 0; l_voff = 64;
    run_one("R6 raw at stride", 6'd11, 1'b1);
    chk("R6 raw oob", 80'(out_oob), 80'(1));
  endtask

  task automatic t_swz_stride0();
    d_swz = 1; d_stride = 0; d_icode = 0; d_ecode = 0; d_num = 40; d_soff = 0;
    l_idx = 3; l_voff = 5; l_inst = 0;
    run_one("R4 swizzle stride0 in", 6'd12, 1'b0);
    chk("R4 swizzled offset 39 below 40", 80'(out_oob), 80'(0));
    d_num = 39;
    run_one("R4 swizzle stride0 out", 6'd13, 1'b0);
    chk("R4 swizzled offset 39 at 39", 80'(out_oob), 80'(1));
  endtask

  task automatic t_wide();
    d_swz = 0; d_soff = 0; d_num = 32'hFFFF_FFFF; d_base = 48'hFFFF_FFFF_0000;
    d_stride = 32'h1_0000; l_idx = 32'h1_0000; l_voff = 0; l_inst = 0;
    run_one("R2 product carry", 6'd14, 1'b0);
    chk("R2 product not truncated", 80'(out_oob), 80'(1));
    d_stride = 0; l_voff = 32'hFFFF_FFF0; l_inst = 32'h20;
    run_one("R1 sum carry", 6'd15, 1'b0);
    chk("R1 carry kept", 80'(out_oob), 80'(1));
    l_voff = 32'hFFFF_0000; l_inst = 32'h100;
    run_one("R7 address wraps", 6'd63, 1'b0);
  endtask

  task automatic t_stream();
    logic [47:0] ea[6];
    bit          eo[6];
    d_swz = 0; d_base = 48'h2000; d_stride = 8; d_num = 64; d_soff = 4; l_inst = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (c >= 2) begin
        chk("R9 stream valid", 80'(out_valid), 80'(1));
        chk("R9 stream lane", 80'(out_lane), 80'(c + 30));
        chk("R7 stream addr", 80'(out_addr), 80'(ea[c-2]));
        chk("R4 stream oob", 80'(out_oob), 80'(eo[c-2]));
      end
      if (c < 6) begin
        in_valid = 1'b1; in_lane = 6'(c + 32); is_store = c[0];
        l_idx = 32'(c); l_voff = 32'(c * 5);
        ea[c] = m_addr(); eo[c] = m_oob();
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk("R9 stream drained", 80'(out_valid), 80'(0));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_linear();
    t_lin_edge();
    t_sat();
    t_swz();
    t_swz_oob();
    t_swz_stride0();
    t_wide();
    t_stream();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R9 actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule